// File: doc/BRIEF.md
# Link Adaptor Bus Register Interface

This block is the processor-facing side of a serial link adaptor. A microprocessor reaches it over a byte-wide bus framed by an active-low chip select. Two register-select bits and a read/write line choose one of four accesses: the received byte, the byte to transmit, and two status registers. Each status register holds one flag and one interrupt enable. The block passes received bytes in from the link receiver, hands bytes to send out to the link transmitter, and raises a request for the receiver side to return an acknowledge.

All bus inputs are sampled on the block clock. An access opens on the clock where chip select is first seen low. It completes on the clock where chip select is first seen high again, and every side effect of the access lands on that edge. The receiver interface follows valid/ready rules. A byte is taken on an edge where both `rx_valid` and `rx_ready` are high, and `rx_ready` is low while a received byte is still unread, so the receiver must hold its byte until then. The transmit interface follows the same rules in the other direction. Once `tx_valid` is raised it stays high, and `tx_data` stays unchanged, until an edge where `tx_ready` is high. The transmitter pulses `tx_done` once the byte has left and its acknowledge has come back.

The data bus is split into an input, an output and an output enable, so the pad ring can build the tristate driver.

Top module: `lbr_top`

## Requirements
- R1: The access code is {rsel[1], rsel[0], rd_wr}, where rd_wr=1 means read. The codes are: 001 reads the received byte, 010 writes the transmit byte, 101 reads input status, 100 writes input status, 111 reads output status, 110 writes output status. Codes 000 and 011 are invalid.
- R2: rsel and rd_wr are latched on the clock where cs_n is first seen low, and changes to them later in the access are ignored. Write data is taken from bus_d_in on the clock where cs_n is first seen high, and that edge is also when the access takes effect.
- R3: bus_d_oe is high only while cs_n is low during an access with a read code. While bus_d_oe is low, bus_d_out is zero.
- R4: In both status registers, bit 0 is the flag and bit 1 is the interrupt enable. Bits 7:2 read as zero.
- R5: The data-present flag (input status bit 0) sets when a byte is accepted on the receive interface. rx_ready equals the inverse of that flag. Completing a read of the received byte clears the flag.
- R6: ack_req pulses high for one cycle, one cycle after a read of the received byte completes, but only if the data-present flag was set at that time.
- R7: Completing a write of the transmit byte loads tx_data, raises tx_valid and clears the output-ready flag (output status bit 0). tx_valid and tx_data hold until an edge where tx_ready is high.
- R8: The output-ready flag sets again only on a tx_done pulse that arrives after the byte has been handed over. A tx_done on the same edge as an output status write sets the flag and also applies the new enable.
- R9: irq_in equals data-present AND its enable, and irq_out equals output-ready AND its enable. Clearing an enable drops its interrupt, and setting the enable again while the flag is still set raises it again.
- R10: After reset, both interrupts are low, both enables are clear, the data-present flag is clear, output-ready is set, bus_d_oe is low and tx_valid is low.
- R11: Writing to a flag bit has no effect. A write with code 000 leaves the received byte unchanged. A read with code 011 returns zero and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Active-low chip select framing one access |
| rsel | input | 2 | Register select |
| rd_wr | input | 1 | 1 = read, 0 = write |
| bus_d_in | input | 8 | Write data from the processor |
| bus_d_out | output | 8 | Read data to the processor |
| bus_d_oe | output | 1 | Drive enable for the data bus |
| rx_data | input | 8 | Byte from the link receiver |
| rx_valid | input | 1 | Receiver offers a byte |
| rx_ready | output | 1 | Block can accept a byte |
| ack_req | output | 1 | One-cycle request to send an acknowledge |
| tx_data | output | 8 | Byte for the link transmitter |
| tx_valid | output | 1 | Byte is offered to the transmitter |
| tx_ready | input | 1 | Transmitter accepts the byte |
| tx_done | input | 1 | Byte sent and its acknowledge received |
| irq_in | output | 1 | Receive interrupt |
| irq_out | output | 1 | Transmit interrupt |

## Verification
Two things can land on the same clock edge. One is a completed output status write that changes the enable. The other is the transmitter's `tx_done`, which sets the output-ready flag. The bench makes them coincide by asserting `tx_done` on the same cycle it raises chip select to end a status write that clears the enable. Afterwards it expects the flag set and `irq_out` low. A later re-enable must then raise `irq_out`. A second overlap is a received byte arriving while enable writes toggle `irq_in`. This is judged by reading the input status register after each step and by popping the expected byte from a scoreboard queue when the byte is read.

// File: rtl/lbr_pkg.sv
package lbr_pkg;
  localparam int DW = 8;
  localparam int FLAG_BIT = 0;
  localparam int IE_BIT = 1;

  typedef enum logic [2:0] {
    ACC_BAD_W    = 3'b000,
    ACC_RD_DATA  = 3'b001,
    ACC_WR_DATA  = 3'b010,
    ACC_BAD_R    = 3'b011,
    ACC_WR_ISTAT = 3'b100,
    ACC_RD_ISTAT = 3'b101,
    ACC_WR_OSTAT = 3'b110,
    ACC_RD_OSTAT = 3'b111
  } acc_code_t;
endpackage

// File: rtl/lbr_strobe.sv
module lbr_strobe
  import lbr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic [1:0] rsel,
  input  logic       rd_wr,
  output acc_code_t  code,
  output logic       done,
  output logic       oe
);
  logic active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      code   <= ACC_BAD_W;
    end else if (!active && !cs_n) begin
      active <= 1'b1;
      code   <= acc_code_t'({rsel, rd_wr});
    end else if (active && cs_n) begin
      active <= 1'b0;
    end
  end

  assign done = active & cs_n;
  assign oe   = active & ~cs_n & code[0];

  // Select is frozen while an access is open
  assert_code_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(code));
endmodule

// File: rtl/lbr_rx_side.sv
module lbr_rx_side
  import lbr_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rx_data,
  input  logic         rx_valid,
  output logic         rx_ready,
  input  logic         done,
  input  acc_code_t    code,
  input  logic         ie_wbit,
  output logic         present,
  output logic         ie,
  output logic [W-1:0] rx_byte,
  output logic         ack_req
);
  logic rd_hit, take;

  assign rd_hit   = done && (code == ACC_RD_DATA);
  assign rx_ready = ~present;
  assign take     = rx_valid & rx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      present <= 1'b0;
      ie      <= 1'b0;
      rx_byte <= '0;
      ack_req <= 1'b0;
    end else begin
      ack_req <= rd_hit && present;
      if (take) begin
        present <= 1'b1;
        rx_byte <= rx_data;
      end else if (rd_hit) begin
        present <= 1'b0;
      end
      if (done && code == ACC_WR_ISTAT) ie <= ie_wbit;
    end
  end

  assert_ack_after_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> ($past(present) && !present));
  assert_rx_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> present);
endmodule

// File: rtl/lbr_tx_side.sv
module lbr_tx_side
  import lbr_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         done,
  input  acc_code_t    code,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] tx_data,
  output logic         tx_valid,
  input  logic         tx_ready,
  input  logic         tx_done,
  output logic         out_ready,
  output logic         ie
);
  logic busy, wr_hit;

  assign wr_hit    = done && (code == ACC_WR_DATA);
  assign out_ready = ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
      ie       <= 1'b0;
    end else begin
      if (wr_hit) begin
        tx_data  <= wdata;
        tx_valid <= 1'b1;
        busy     <= 1'b1;
      end else begin
        if (tx_valid && tx_ready) tx_valid <= 1'b0;
        if (tx_done && busy && !tx_valid) busy <= 1'b0;
      end
      if (done && code == ACC_WR_OSTAT) ie <= wdata[IE_BIT];
    end
  end

  assert_tx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  assert_ready_from_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_ready) |-> $past(tx_done));
endmodule

// File: rtl/lbr_top.sv
module lbr_top
  import lbr_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic [1:0]   rsel,
  input  logic         rd_wr,
  input  logic [W-1:0] bus_d_in,
  output logic [W-1:0] bus_d_out,
  output logic         bus_d_oe,
  input  logic [W-1:0] rx_data,
  input  logic         rx_valid,
  output logic         rx_ready,
  output logic         ack_req,
  output logic [W-1:0] tx_data,
  output logic         tx_valid,
  input  logic         tx_ready,
  input  logic         tx_done,
  output logic         irq_in,
  output logic         irq_out
);
  acc_code_t    code;
  logic         done, oe;
  logic         present, ie_in, out_ready, ie_out;
  logic [W-1:0] rx_byte, rdata, istat, ostat;

  lbr_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rsel(rsel), .rd_wr(rd_wr),
    .code(code), .done(done), .oe(oe)
  );

  lbr_rx_side #(.W(W)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .done(done), .code(code), .ie_wbit(bus_d_in[IE_BIT]),
    .present(present), .ie(ie_in), .rx_byte(rx_byte), .ack_req(ack_req)
  );

  lbr_tx_side #(.W(W)) u_tx (
    .clk(clk), .rst_n(rst_n), .done(done), .code(code), .wdata(bus_d_in),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_done(tx_done), .out_ready(out_ready), .ie(ie_out)
  );

  always_comb begin
    istat = '0;
    istat[FLAG_BIT] = present;
    istat[IE_BIT]   = ie_in;
    ostat = '0;
    ostat[FLAG_BIT] = out_ready;
    ostat[IE_BIT]   = ie_out;
    case (code)
      ACC_RD_DATA:  rdata = rx_byte;
      ACC_RD_ISTAT: rdata = istat;
      ACC_RD_OSTAT: rdata = ostat;
      default:      rdata = '0;
    endcase
  end

  assign bus_d_oe  = oe;
  assign bus_d_out = oe ? rdata : '0;
  assign irq_in    = present & ie_in;
  assign irq_out   = out_ready & ie_out;

  assert_drive_needs_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_d_oe |-> !cs_n);
  assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_in || irq_out) |-> (ie_in || ie_out));
  assert_quiet_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_d_oe |-> (bus_d_out == '0));
endmodule

// File: tb/sim_lbr_top.sv
`timescale 1ns/1ps
module sim_lbr_top;
  logic       clk = 0, rst_n = 0, cs_n = 1, rd_wr = 1;
  logic [1:0] rsel = 0;
  logic [7:0] bus_d_in = 0, rx_data = 0;
  logic       rx_valid = 0, tx_ready = 1, tx_done = 0;
  logic [7:0] bus_d_out, tx_data;
  logic       bus_d_oe, rx_ready, ack_req, tx_valid, irq_in, irq_out;

  int n_vec = 0, n_bad = 0, ack_cnt = 0;
  logic [7:0] rxq[$];
  logic [7:0] txq[$];

  always #4 clk = ~clk;

  lbr_top u0 (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Bus access: returns sampled read data and drive-enable mid-access
  task automatic acc(input logic [1:0] rs, input logic rw, input logic [7:0] wd,
                     input logic inj_done, output logic [7:0] rd, output logic oe_seen);
    @(negedge clk); rsel = rs; rd_wr = rw; cs_n = 0;
    @(negedge clk); #1;
    rd = bus_d_out; oe_seen = bus_d_oe;
    rsel = ~rs; rd_wr = ~rw;
    cs_n = 1; bus_d_in = wd; tx_done = inj_done;
    @(negedge clk); tx_done = 0; bus_d_in = 0; #1;
  endtask

  task automatic send_rx(input logic [7:0] b);
    @(negedge clk);
    while (!rx_ready) @(negedge clk);
    rx_valid = 1; rx_data = b; rxq.push_back(b);
    @(negedge clk); rx_valid = 0; #1;
  endtask

  // Monitor: scoreboard pop on transmit handshake, acknowledge pulse count
  initial forever begin
    @(negedge clk); #2;
    if (rst_n && ack_req) ack_cnt++;
    if (rst_n && tx_valid && tx_ready) begin
      if (txq.size() == 0) chk("R7 unexpected tx", tx_data, 8'hxx);
      else chk("R7 tx byte", tx_data, txq.pop_front());
    end
  end

  initial begin
    #800000;
    n_bad++; n_vec++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] r; logic oe; int acks;
    repeat (4) @(negedge clk);
    rst_n = 1; #1;
    chk("R10 oe", bus_d_oe, 0);
    chk("R10 irq_in", irq_in, 0);
    chk("R10 irq_out", irq_out, 0);
    chk("R10 tx_valid", tx_valid, 0);
    chk("R10 rx_ready", rx_ready, 1);
    acc(2'b10, 1, 0, 0, r, oe); chk("R10 istat", r, 8'h00); chk("R3 oe on read", oe, 1);
    acc(2'b11, 1, 0, 0, r, oe); chk("R4 ostat after reset", r, 8'h01);
    chk("R3 oe idle", bus_d_oe, 0);
    // Enable output interrupt
    acc(2'b11, 0, 8'h02, 0, r, oe); chk("R3 no drive on write", oe, 0);
    chk("R9 irq_out raised", irq_out, 1);
    acc(2'b11, 1, 0, 0, r, oe); chk("R4 ostat", r, 8'h03);
    // Flag bit write ignored
    acc(2'b10, 0, 8'h01, 0, r, oe);
    acc(2'b10, 1, 0, 0, r, oe); chk("R11 flag write ignored", r, 8'h00);
    // Receive path
    send_rx(8'hA5);
    chk("R5 rx_ready low", rx_ready, 0);
    acc(2'b10, 1, 0, 0, r, oe); chk("R5 present", r, 8'h01);
    chk("R9 irq_in gated", irq_in, 0);
    acc(2'b10, 0, 8'h02, 0, r, oe); chk("R9 irq_in raised", irq_in, 1);
    acc(2'b10, 0, 8'h00, 0, r, oe); chk("R9 irq_in dropped", irq_in, 0);
    acc(2'b10, 0, 8'h02, 0, r, oe); chk("R9 irq_in re-raised", irq_in, 1);
    acks = ack_cnt;
    acc(2'b00, 1, 0, 0, r, oe); chk("R1 read data", r, rxq.pop_front());
    #2; chk("R6 ack pulse", 8'(ack_cnt), 8'(acks + 1));
    chk("R5 cleared irq_in", irq_in, 0);
    acc(2'b10, 1, 0, 0, r, oe); chk("R5 istat after read", r, 8'h02);
    acks = ack_cnt;
    acc(2'b00, 1, 0, 0, r, oe);
    @(negedge clk); #2; chk("R6 no ack when empty", 8'(ack_cnt), 8'(acks));
    // Invalid codes
    send_rx(8'h3C);
    acc(2'b00, 0, 8'hFF, 0, r, oe);
    acc(2'b10, 1, 0, 0, r, oe); chk("R11 bad write no effect", r, 8'h03);
    acc(2'b01, 1, 0, 0, r, oe); chk("R11 code 011 reads zero", r, 8'h00);
    acc(2'b11, 1, 0, 0, r, oe); chk("R11 code 011 no state change", r, 8'h03);
    acc(2'b00, 1, 0, 0, r, oe); chk("R2 latched data read", r, rxq.pop_front());
    // Transmit with back-pressure
    tx_ready = 0;
    txq.push_back(8'h5A);
    acc(2'b01, 0, 8'h5A, 0, r, oe);
    chk("R7 tx_valid", tx_valid, 1);
    chk("R9 irq_out dropped", irq_out, 0);
    repeat (3) @(negedge clk); #1;
    chk("R7 tx held", tx_data, 8'h5A);
    acc(2'b11, 1, 0, 0, r, oe); chk("R7 ostat busy", r, 8'h02);
    @(negedge clk); tx_ready = 1;
    @(negedge clk); #3; chk("R7 handed over", tx_valid, 0);
    acc(2'b11, 1, 0, 0, r, oe); chk("R8 still busy", r, 8'h02);
    @(negedge clk); tx_done = 1; @(negedge clk); tx_done = 0; #1;
    chk("R8 irq_out after done", irq_out, 1);
    // Collision: disable enable on the tx_done edge
    txq.push_back(8'hC3);
    acc(2'b01, 0, 8'hC3, 0, r, oe);
    repeat (2) @(negedge clk);
    acc(2'b11, 0, 8'h00, 1, r, oe);
    chk("R8 collision irq_out", irq_out, 0);
    acc(2'b11, 1, 0, 0, r, oe); chk("R8 collision ostat", r, 8'h01);
    acc(2'b11, 0, 8'h02, 0, r, oe); chk("R9 irq_out re-raised", irq_out, 1);
    chk("R7 scoreboard empty", 8'(txq.size()), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule